// File: doc/BRIEF.md
# Four-Wide Decode Slot Allocator

This block sits between a two-thread instruction queue and the decoders of an out-of-order core. Pre-decoded instruction records enter on a valid/ready stream tagged with a thread number. Each record holds a tag, a length (1 to 15 bytes), a micro-op count (1 to 4), a fuse-head flag for a compare/test, and a fuse-branch flag for a conditional branch. The records are stored in one of two equal halves of the queue. Each cycle the allocator picks one thread and builds a decode group from the oldest records of that thread. The group has one complex slot (slot 0), which accepts any micro-op count, and three simple slots, which accept only single-micro-op instructions.

When a compare/test is immediately followed by a conditional branch, the pair is merged into one slot that carries a single micro-op. Because of this merging, a group can consume five instructions instead of four. Groups leave through a registered valid/ready output. The output register is the only place where back-pressure acts: while `out_ready` is low the held group does not change, no new group is formed and nothing is popped. On the input side `in_ready` stays low for a thread whose half is full, and the sender must hold its record until it is accepted. A per-thread flush empties only that thread's half, and it also discards a group of that thread that is waiting at the output.

Top module: `dec_slot_alloc`

## Requirements
- R1: Each thread's half holds QDEPTH (default 20) records. `in_ready` is low for the thread selected by `in_tid` when its half is full or that thread is being flushed. The state of the other thread never affects this.
- R2: The oldest record of the chosen thread always goes to slot 0, whatever its micro-op count (1 to 4). `out_slot_uops[0]` reports that count, and `out_slot_valid[0]` is 1 whenever `out_valid` is 1.
- R3: Slots 1 to 3 take only records with a micro-op count of 1. A multi-micro-op record that is not first stops the group before it and then opens the next group in slot 0.
- R4: A fuse-head record with one micro-op, directly followed in the same thread by a fuse-branch record with one micro-op, takes one slot with its `out_slot_fused` bit set and one micro-op. Both records are consumed. A group holds at most one fused pair, so it consumes at most five records. A fuse-head followed by a record that is not a branch is not fused.
- R5: Fusion never spans two groups. If the branch is not yet queued when the group holding its fuse-head is formed, the head leaves unfused and the branch later leaves in a group of its own.
- R6: When both threads hold records, successive groups alternate between the threads. When only one thread holds records, that thread is chosen.
- R7: A queue pops exactly the records its group consumed. Each record leaves exactly once, in push order within its thread, with slots in program order and a fused branch directly behind its head.
- R8: Asserting `flush[t]` for one cycle empties thread t's half and drops a waiting output group of thread t. Records of the other thread are kept.
- R9: A group appears on `out_valid` at the earliest one cycle after its first record is accepted. While `out_ready` is low, `out_valid` and every output field hold their values.
- R10: After reset `out_valid` is 0, both halves are empty and `in_ready` is 1.
- R11: `out_inst_count` equals the number of valid slots plus the number of fused slots. `out_uop_count` equals the sum of the micro-op counts of the valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input record is offered |
| in_ready | output | 1 | The half named by in_tid can take the record |
| in_tid | input | 1 | Thread of the offered record |
| in_tag | input | 8 | Instruction tag |
| in_len | input | 4 | Instruction length in bytes, 1 to 15 |
| in_uops | input | 3 | Micro-op count, 1 to 4 |
| in_fuse_head | input | 1 | Record is a compare/test that can lead a fused pair |
| in_fuse_br | input | 1 | Record is a conditional branch that can end a fused pair |
| flush | input | 2 | Per-thread flush, one bit per thread |
| out_valid | output | 1 | A decode group is presented |
| out_ready | input | 1 | Consumer accepts the group |
| out_tid | output | 1 | Thread of the group |
| out_slot_valid | output | 4 | Slot occupied, bit 0 is the complex slot |
| out_slot_fused | output | 4 | Slot carries a fused compare+branch pair |
| out_slot_tag | output | 4x8 | Tag of the first record in each slot |
| out_slot_len | output | 4x4 | Length of the first record in each slot |
| out_slot_uops | output | 4x3 | Micro-op count of each slot |
| out_inst_count | output | 3 | Records consumed by the group |
| out_uop_count | output | 3 | Micro-ops emitted by the group |

## Verification
Several functions can act in the same cycle. A flush of one thread can land while that thread's group is waiting at a stalled output and the other thread still has records. The bench provokes this by holding `out_ready` low: the dropped group must vanish one edge later, and the next group must come from the surviving thread. In the same way, a stall lets both halves fill, so that releasing the stall makes the thread choice and the stop on a multi-micro-op record, or a fusion together with a second fuse-head candidate, decide one group together. The expected slot masks, counts and thread order of every group are written down in the bench, and a scoreboard keeps a separate copy of each thread's records to check ordering.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  parameter int TAG_W     = 8;
  parameter int LEN_W     = 4;
  parameter int UOP_W     = 3;
  parameter int MAX_UOPS  = 4;
  parameter int NSLOT     = 4;
  parameter int NTHR      = 2;
  parameter int WIN       = NSLOT + 1;
  parameter int CNT_W     = $clog2(WIN + 1);
  parameter int UCNT_W    = $clog2(MAX_UOPS + NSLOT);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [LEN_W-1:0] len;
    logic [UOP_W-1:0] uops;
    logic             fuse_head;
    logic             fuse_br;
  } inst_t;
endpackage

// File: rtl/dsa_thread_queue.sv
module dsa_thread_queue
  import dsa_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  push,
  input  inst_t                 push_data,
  input  logic [CNT_W-1:0]      pop_n,
  output logic                  full,
  output logic [WIN-1:0]        peek_vld,
  output inst_t [WIN-1:0]       peek
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  inst_t          mem [DEPTH];
  logic [IW-1:0]  head_q, tail_q;
  logic [CW-1:0]  cnt_q;

  function automatic logic [IW-1:0] adv(input logic [IW-1:0] base, input int unsigned n);
    int unsigned s;
    s = int'(base) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return s[IW-1:0];
  endfunction

  assign full = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= adv(tail_q, 1);
      head_q <= adv(head_q, int'(pop_n));
      cnt_q  <= cnt_q + CW'(push) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[tail_q] <= push_data;
  end

  for (genvar k = 0; k < WIN; k++) begin : g_peek
    assign peek[k]     = mem[adv(head_q, k)];
    assign peek_vld[k] = (cnt_q > CW'(k));
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r7_pop_le_count: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (CW'(pop_n) <= cnt_q));
endmodule

// File: rtl/dsa_thread_pick.sv
module dsa_thread_pick
  import dsa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] has_work,
  input  logic            advance,
  output logic            sel
);
  logic last_q;

  always_comb begin
    if (&has_work) sel = ~last_q;
    else           sel = has_work[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b1;
    else if (advance) last_q <= sel;
  end

  a_r6_pick_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    (|has_work) |-> has_work[sel]);
endmodule

// File: rtl/dsa_group_former.sv
module dsa_group_former
  import dsa_pkg::*;
(
  input  logic [WIN-1:0]    peek_vld,
  input  inst_t [WIN-1:0]   peek,
  output logic [NSLOT-1:0]  slot_vld,
  output logic [NSLOT-1:0]  slot_fused,
  output inst_t [NSLOT-1:0] slot_rec,
  output logic [CNT_W-1:0]  n_inst,
  output logic [UCNT_W-1:0] n_uop
);
  always_comb begin : form
    int   p;
    logic stop;
    logic fused_used;
    p          = 0;
    stop       = 1'b0;
    fused_used = 1'b0;
    slot_vld   = '0;
    slot_fused = '0;
    slot_rec   = '0;
    n_uop      = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (!stop && p < WIN && peek_vld[p]) begin
        if (s != 0 && peek[p].uops != UOP_W'(1)) begin
          stop = 1'b1;
        end else begin
          slot_vld[s] = 1'b1;
          slot_rec[s] = peek[p];
          n_uop       = n_uop + UCNT_W'(peek[p].uops);
          if (!fused_used && peek[p].fuse_head && peek[p].uops == UOP_W'(1) &&
              (p + 1) < WIN && peek_vld[p+1] && peek[p+1].fuse_br &&
              peek[p+1].uops == UOP_W'(1)) begin
            slot_fused[s] = 1'b1;
            fused_used    = 1'b1;
            p             = p + 2;
          end else begin
            p = p + 1;
          end
        end
      end else begin
        stop = 1'b1;
      end
    end
    n_inst = CNT_W'(p);
  end
endmodule

// File: rtl/dec_slot_alloc.sv
module dec_slot_alloc
  import dsa_pkg::*;
#(
  parameter int QDEPTH = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_tid,
  input  logic [TAG_W-1:0]             in_tag,
  input  logic [LEN_W-1:0]             in_len,
  input  logic [UOP_W-1:0]             in_uops,
  input  logic                         in_fuse_head,
  input  logic                         in_fuse_br,
  input  logic [NTHR-1:0]              flush,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_tid,
  output logic [NSLOT-1:0]             out_slot_valid,
  output logic [NSLOT-1:0]             out_slot_fused,
  output logic [NSLOT-1:0][TAG_W-1:0]  out_slot_tag,
  output logic [NSLOT-1:0][LEN_W-1:0]  out_slot_len,
  output logic [NSLOT-1:0][UOP_W-1:0]  out_slot_uops,
  output logic [CNT_W-1:0]             out_inst_count,
  output logic [UCNT_W-1:0]            out_uop_count
);
  inst_t                         push_rec;
  logic [NTHR-1:0]               q_full, has_work;
  logic [NTHR-1:0][WIN-1:0]      pv;
  inst_t [NTHR-1:0][WIN-1:0]     pk;
  logic [NTHR-1:0][CNT_W-1:0]    popn;
  logic                          sel, load;
  logic [NSLOT-1:0]              g_vld, g_fused;
  inst_t [NSLOT-1:0]             g_rec;
  logic [CNT_W-1:0]              g_ninst;
  logic [UCNT_W-1:0]             g_nuop;

  assign push_rec = '{tag: in_tag, len: in_len, uops: in_uops,
                      fuse_head: in_fuse_head, fuse_br: in_fuse_br};
  assign in_ready = !q_full[in_tid] && !flush[in_tid];
  assign load     = (|has_work) && !flush[sel] && (!out_valid || out_ready);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign has_work[t] = pv[t][0];
    assign popn[t]     = (load && sel == 1'(t)) ? g_ninst : '0;
    dsa_thread_queue #(.DEPTH(QDEPTH)) i_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush[t]),
      .push     (in_valid && in_ready && in_tid == 1'(t)),
      .push_data(push_rec),
      .pop_n    (popn[t]),
      .full     (q_full[t]),
      .peek_vld (pv[t]),
      .peek     (pk[t])
    );
  end

  dsa_thread_pick i_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .has_work(has_work),
    .advance (load),
    .sel     (sel)
  );

  dsa_group_former i_form (
    .peek_vld  (pv[sel]),
    .peek      (pk[sel]),
    .slot_vld  (g_vld),
    .slot_fused(g_fused),
    .slot_rec  (g_rec),
    .n_inst    (g_ninst),
    .n_uop     (g_nuop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_tid        <= 1'b0;
      out_slot_valid <= '0;
      out_slot_fused <= '0;
      out_slot_tag   <= '0;
      out_slot_len   <= '0;
      out_slot_uops  <= '0;
      out_inst_count <= '0;
      out_uop_count  <= '0;
    end else if (load) begin
      out_valid      <= 1'b1;
      out_tid        <= sel;
      out_slot_valid <= g_vld;
      out_slot_fused <= g_fused;
      out_inst_count <= g_ninst;
      out_uop_count  <= g_nuop;
      for (int s = 0; s < NSLOT; s++) begin
        out_slot_tag[s]  <= g_rec[s].tag;
        out_slot_len[s]  <= g_rec[s].len;
        out_slot_uops[s] <= g_rec[s].uops;
      end
    end else if (out_valid && (out_ready || flush[out_tid])) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush[out_tid]) |=>
      (out_valid && $stable(out_slot_tag) && $stable(out_tid) &&
       $stable(out_slot_valid) && $stable(out_inst_count)));
  a_r2_head_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot_valid[0]);
  a_r4_one_fusion: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_slot_fused) <= 1 && int'(out_inst_count) <= WIN));
  a_r11_inst_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_inst_count) ==
                   $countones(out_slot_valid) + $countones(out_slot_fused)));
  a_r8_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && flush[out_tid]) |=> !out_valid);

  for (genvar s = 1; s < NSLOT; s++) begin : g_simple_chk
    a_r3_simple_single: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_slot_valid[s]) |-> (out_slot_uops[s] == UOP_W'(1)));
  end
endmodule

// File: tb/test_dec_slot_alloc.sv
module test_dec_slot_alloc;
  import dsa_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                        rst_n = 1'b0;
  logic                        in_valid = 1'b0;
  logic                        in_ready;
  logic                        in_tid = 1'b0;
  logic [TAG_W-1:0]            in_tag = '0;
  logic [LEN_W-1:0]            in_len = '0;
  logic [UOP_W-1:0]            in_uops = '0;
  logic                        in_fuse_head = 1'b0;
  logic                        in_fuse_br = 1'b0;
  logic [NTHR-1:0]             flush = '0;
  logic                        out_valid;
  logic                        out_ready = 1'b0;
  logic                        out_tid;
  logic [NSLOT-1:0]            out_slot_valid, out_slot_fused;
  logic [NSLOT-1:0][TAG_W-1:0] out_slot_tag;
  logic [NSLOT-1:0][LEN_W-1:0] out_slot_len;
  logic [NSLOT-1:0][UOP_W-1:0] out_slot_uops;
  logic [CNT_W-1:0]            out_inst_count;
  logic [UCNT_W-1:0]           out_uop_count;

  dec_slot_alloc i_dec_slot_alloc (.*);

  typedef struct {
    logic [7:0] tag;
    logic [3:0] len;
    logic [2:0] uops;
    logic       fh;
    logic       fb;
  } rec_t;

  rec_t mq0[$];
  rec_t mq1[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit c, input string rq, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit popm(input logic t, output rec_t r);
    if (t == 1'b0) begin
      if (mq0.size() == 0) return 1'b0;
      r = mq0.pop_front();
    end else begin
      if (mq1.size() == 0) return 1'b0;
      r = mq1.pop_front();
    end
    return 1'b1;
  endfunction

  // Scoreboard monitor: every accepted group is matched against the per-thread model (R7)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (out_slot_valid[s]) begin
          rec_t e, b;
          bit ok;
          ok = popm(out_tid, e);
          chk(ok && e.tag == out_slot_tag[s] && e.uops == out_slot_uops[s] &&
              e.len == out_slot_len[s], "R7 slot record", out_slot_tag[s], ok ? e.tag : 8'hxx);
          if (s > 0) chk(out_slot_uops[s] == 3'd1, "R3 simple slot uops", out_slot_uops[s], 1);
          if (out_slot_fused[s]) begin
            ok = popm(out_tid, b);
            chk(ok && e.fh && b.fb && b.uops == 3'd1, "R4 fused pair members",
                ok ? b.tag : 8'hxx, 1);
          end
        end
      end
    end
  end

  task automatic push(input logic t, input logic [7:0] tg, input logic [2:0] u,
                      input logic fh, input logic fb);
    rec_t r;
    @(posedge clk); #1;
    in_valid = 1'b1; in_tid = t; in_tag = tg; in_uops = u;
    in_fuse_head = fh; in_fuse_br = fb; in_len = tg[3:0] | 4'd1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    r.tag = tg; r.len = tg[3:0] | 4'd1; r.uops = u; r.fh = fh; r.fb = fb;
    if (t == 1'b0) mq0.push_back(r); else mq1.push_back(r);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_group(input logic t, input int ic, input int uc,
                              input logic [3:0] vm, input logic [3:0] fm,
                              input logic [7:0] tg, input string rq);
    int w;
    w = 0;
    do begin @(negedge clk); w++; end while (!(out_valid && out_ready) && w < 300);
    chk(out_valid && out_ready, {rq, " group present"}, out_valid, 1);
    chk(out_tid == t, {rq, " thread"}, out_tid, t);
    chk(out_slot_valid == vm, {rq, " slot mask"}, out_slot_valid, vm);
    chk(out_slot_fused == fm, {rq, " fused mask"}, out_slot_fused, fm);
    chk(out_slot_tag[0] == tg, {rq, " head tag"}, out_slot_tag[0], tg);
    chk(int'(out_inst_count) == ic, "R11 inst count", out_inst_count, ic);
    chk(int'(out_uop_count) == uc, "R11 uop count", out_uop_count, uc);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 out_ready = v;
  endtask

  task automatic drain();
    set_ready(1'b1);
    repeat (30) @(negedge clk);
  endtask

  task automatic do_flush(input int t);
    @(posedge clk); #1 flush[t] = 1'b1;
    @(posedge clk);
    if (t == 0) mq0.delete(); else mq1.delete();
    #1 flush = '0;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    logic [NSLOT-1:0][TAG_W-1:0] snap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready, "R10 in_ready after reset", in_ready, 1);

    // R2/R3/R9: complex slot, stop before a multi-uop record, stall stability
    push(0, 8'h10, 1, 0, 0);
    push(0, 8'h11, 1, 0, 0); push(0, 8'h12, 1, 0, 0);
    push(0, 8'h13, 3, 0, 0); push(0, 8'h14, 1, 0, 0);
    push(0, 8'h15, 3, 0, 0); push(0, 8'h16, 1, 0, 0);
    push(0, 8'h17, 1, 0, 0); push(0, 8'h18, 1, 0, 0);
    @(negedge clk);
    snap = out_slot_tag;
    repeat (3) @(negedge clk);
    chk(out_valid && out_slot_tag == snap && out_inst_count == 3'd1, "R9 held while stalled",
        out_slot_tag[0], snap[0]);
    set_ready(1'b1);
    expect_group(0, 1, 1, 4'b0001, 4'b0000, 8'h10, "R9 primer");
    expect_group(0, 2, 2, 4'b0011, 4'b0000, 8'h11, "R3 stop before multi-uop");
    expect_group(0, 2, 4, 4'b0011, 4'b0000, 8'h13, "R2 multi-uop in complex slot");
    expect_group(0, 4, 6, 4'b1111, 4'b0000, 8'h15, "R2 full group");
    drain();

    // R4: fusion, one pair per group, five records consumed
    set_ready(1'b0);
    push(0, 8'h30, 1, 0, 0);
    push(0, 8'h31, 1, 1, 0); push(0, 8'h32, 1, 0, 1);
    push(0, 8'h33, 1, 1, 0); push(0, 8'h34, 1, 0, 1);
    push(0, 8'h35, 1, 0, 0); push(0, 8'h36, 1, 0, 0); push(0, 8'h37, 1, 0, 0);
    set_ready(1'b1);
    expect_group(0, 1, 1, 4'b0001, 4'b0000, 8'h30, "R4 primer");
    expect_group(0, 5, 4, 4'b1111, 4'b0001, 8'h31, "R4 single fusion of five");
    expect_group(0, 2, 2, 4'b0011, 4'b0000, 8'h36, "R4 remainder");
    drain();

    set_ready(1'b0);
    push(0, 8'h40, 1, 0, 0);
    push(0, 8'h41, 1, 0, 0); push(0, 8'h42, 1, 0, 0); push(0, 8'h43, 1, 0, 0);
    push(0, 8'h44, 1, 1, 0); push(0, 8'h45, 1, 0, 1);
    push(0, 8'h46, 1, 1, 0); push(0, 8'h47, 1, 0, 0);
    set_ready(1'b1);
    expect_group(0, 1, 1, 4'b0001, 4'b0000, 8'h40, "R4 primer");
    expect_group(0, 5, 4, 4'b1111, 4'b1000, 8'h41, "R4 pair in last slot");
    expect_group(0, 2, 2, 4'b0011, 4'b0000, 8'h46, "R4 head without branch");
    drain();

    // R5: branch arriving after its head was grouped stays separate
    fork
      begin
        push(0, 8'h50, 1, 1, 0);
        repeat (3) @(posedge clk);
        push(0, 8'h51, 1, 0, 1);
      end
      begin
        expect_group(0, 1, 1, 4'b0001, 4'b0000, 8'h50, "R5 head alone");
        expect_group(0, 1, 1, 4'b0001, 4'b0000, 8'h51, "R5 branch alone");
      end
    join
    drain();

    // R6: alternation between threads
    set_ready(1'b0);
    push(0, 8'h60, 1, 0, 0);
    push(0, 8'h61, 1, 0, 0); push(0, 8'h62, 1, 0, 0);
    push(1, 8'h70, 1, 0, 0); push(1, 8'h71, 1, 0, 0);
    set_ready(1'b1);
    expect_group(0, 1, 1, 4'b0001, 4'b0000, 8'h60, "R6 only thread 0");
    expect_group(1, 2, 2, 4'b0011, 4'b0000, 8'h70, "R6 switch to thread 1");
    expect_group(0, 2, 2, 4'b0011, 4'b0000, 8'h61, "R6 back to thread 0");
    drain();

    // R8: flush thread 0 while its group waits; thread 1 survives
    set_ready(1'b0);
    push(0, 8'h80, 1, 0, 0);
    push(0, 8'h81, 2, 0, 0);
    push(1, 8'h90, 4, 0, 0);
    do_flush(0);
    @(negedge clk);
    chk(!out_valid, "R8 waiting group dropped", out_valid, 0);
    set_ready(1'b1);
    expect_group(1, 1, 4, 4'b0001, 4'b0000, 8'h90, "R8 other thread kept");
    repeat (10) @(negedge clk);
    chk(!out_valid, "R8 flushed thread emits nothing", out_valid, 0);
    drain();

    // R1: capacity of one half, the other half unaffected
    set_ready(1'b0);
    for (int i = 0; i < 21; i++) push(1, 8'hA0 + 8'(i), 1, 0, 0);
    @(posedge clk); #1 in_tid = 1'b1;
    @(negedge clk);
    chk(!in_ready, "R1 full half refuses", in_ready, 0);
    in_tid = 1'b0;
    #1 chk(in_ready, "R1 other half still ready", in_ready, 1);
    drain();

    chk(mq0.size() == 0 && mq1.size() == 0, "R7 every record emitted once",
        mq0.size() + mq1.size(), 0);
    report();
    $finish;
  end
endmodule